// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block takes a set of external interrupt pins, brings each one into the clock domain through a two-flop synchronizer, and turns it into a per-pin interrupt line for a processor. Software chooses, pin by pin, which condition raises an interrupt. The choices are an active-low level, an active-high level, a rising edge, a falling edge, or either edge. Each pin has a detect bit and an enable bit. Its output line is high while both bits are set.

Software reaches the block through a plain 32-bit register port with separate read and write strobes. Enables are turned on through one address and turned off through another. A latched edge is acknowledged by writing a one to its detect bit. In the registers, pin n always sits at bit n. The pin count is a parameter from 1 to 32.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every enable, every detect bit, every sense code and every `irq_out` line is 0.
- R2: Pin n has a sense register at byte address 0x180 + 4*n. Bits [5:0] hold the sense code, and bits [31:6] read as 0 and ignore writes. The codes are: 0x01 active-low level, 0x02 active-high level, 0x04 falling edge, 0x08 rising edge, 0x0C either edge. Any other code (0x00, 0x03, 0x3F, ...) keeps the detect bit at 0.
- R3: In a level mode, the detect bit follows the synchronized level. Writing a 1 to it at 0x100 while the level is still active leaves it set.
- R4: In an edge mode, a detected edge sets the detect bit, and the bit stays set until a 1 is written to that bit at address 0x100. Writing a 0 there leaves the bit unchanged.
- R5: If an edge is detected in the same cycle as a clear write to that pin's detect bit, the detect bit stays set.
- R6: Writing a 1 to bit n at 0x008 enables pin n. Writing a 1 to bit n at 0x004 disables it. Zero bits leave the enable unchanged. A read at either address returns the current enables.
- R7: A read at 0x000 returns detect AND enable. `irq_out[n]` is high exactly when detect bit n and enable bit n are both set.
- R8: A read at 0x104 returns the synchronized level of every pin. A pin change is seen there after two clock edges, and in the detect bit after three.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is high and otherwise holds. Bits at or above the pin count read as 0, and addresses that are not decoded read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | NUM_PINS | Per-pin interrupt line to the processor |

## Verification
The two things that can fall in the same cycle are a new edge reaching the detector and software's write-one acknowledge of the same pin. The bench latches an edge on a rising-edge pin and then lets the input fall. It then raises the pin again and counts two clock edges, so that its acknowledge write is sampled on the exact edge where the new edge is detected. It expects the detect bit to read back as 1. A second acknowledge with no edge present must then clear the bit. Level mode gets a matching check: an acknowledge while the level is still active must not clear the bit.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int unsigned ADDR_W = 12;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_REQ    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_DET    = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_MON    = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 12'h180;

    // Sense codes
    localparam logic [5:0] SENSE_LVL_LO = 6'h01;
    localparam logic [5:0] SENSE_LVL_HI = 6'h02;
    localparam logic [5:0] SENSE_FALL   = 6'h04;
    localparam logic [5:0] SENSE_RISE   = 6'h08;
    localparam logic [5:0] SENSE_BOTH   = 6'h0C;

    typedef enum logic [2:0] {
        MODE_OFF,
        MODE_LO,
        MODE_HI,
        MODE_FALL,
        MODE_RISE,
        MODE_BOTH
    } sense_mode_e;

    function automatic sense_mode_e decode_sense(input logic [5:0] code);
        case (code)
            SENSE_LVL_LO: return MODE_LO;
            SENSE_LVL_HI: return MODE_HI;
            SENSE_FALL:   return MODE_FALL;
            SENSE_RISE:   return MODE_RISE;
            SENSE_BOTH:   return MODE_BOTH;
            default:      return MODE_OFF;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
        return OFS_CFG + ADDR_W'(4 * idx);
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prev
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] lvl;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw;
        s_d.lvl  = s_q.meta;
        s_d.prev = s_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl  = s_q.lvl;
    assign prev = s_q.prev;

    // R8: the monitored level is the raw input delayed by two edges
    a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.meta == s_q.meta |=> lvl == $past(s_q.meta));

endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] sense,
    input  logic       lvl,
    input  logic       prev,
    input  logic       clr,
    output logic       det
);

    typedef struct packed {
        logic det;
    } det_t;

    det_t        d_d, d_q;
    sense_mode_e mode;
    logic        rise, fall;

    always_comb begin
        mode = decode_sense(sense);
        rise = lvl & ~prev;
        fall = ~lvl & prev;
        d_d  = d_q;
        unique case (mode)
            MODE_LO:   d_d.det = ~lvl;
            MODE_HI:   d_d.det = lvl;
            MODE_FALL: d_d.det = fall | (d_q.det & ~clr);
            MODE_RISE: d_d.det = rise | (d_q.det & ~clr);
            MODE_BOTH: d_d.det = rise | fall | (d_q.det & ~clr);
            default:   d_d.det = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign det = d_q.det;

    a_r2_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sense != SENSE_LVL_LO && sense != SENSE_LVL_HI && sense != SENSE_FALL &&
         sense != SENSE_RISE && sense != SENSE_BOTH) |=> !det);

    a_r3_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_LVL_HI) |=> det == $past(lvl));

    a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((sense == SENSE_RISE || sense == SENSE_FALL || sense == SENSE_BOTH) &&
         det && !clr) |=> det);

    a_r5_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((sense == SENSE_RISE || sense == SENSE_BOTH) && lvl && !prev && clr) |=> det);

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_out
);

    localparam int unsigned N = NUM_PINS;

    typedef struct packed {
        logic [N-1:0]      en;
        logic [N-1:0][5:0] cfg;
        logic [31:0]       rdata;
    } regs_t;

    regs_t        r_d, r_q;
    logic [N-1:0] lvl, prev, det, clr;
    logic [N-1:0] wmask;
    logic [31:0]  rd_val;
    logic         unused_wdata;

    assign unused_wdata = ^bus_wdata;

    extint_sync #(.WIDTH(N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .lvl  (lvl),
        .prev (prev)
    );

    for (genvar g = 0; g < N; g++) begin : g_pin
        extint_detect u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .sense(r_q.cfg[g]),
            .lvl  (lvl[g]),
            .prev (prev[g]),
            .clr  (clr[g]),
            .det  (det[g])
        );
    end

    always_comb begin
        r_d    = r_q;
        clr    = '0;
        wmask  = bus_wdata[N-1:0];
        rd_val = '0;

        if (bus_wr) begin
            case (bus_addr)
                OFS_EN_SET: r_d.en = r_q.en | wmask;
                OFS_EN_CLR: r_d.en = r_q.en & ~wmask;
                OFS_DET:    clr    = wmask;
                default: begin
                    for (int i = 0; i < N; i++) begin
                        if (bus_addr == cfg_addr(i)) r_d.cfg[i] = bus_wdata[5:0];
                    end
                end
            endcase
        end

        case (bus_addr)
            OFS_REQ:    rd_val[N-1:0] = det & r_q.en;
            OFS_EN_CLR: rd_val[N-1:0] = r_q.en;
            OFS_EN_SET: rd_val[N-1:0] = r_q.en;
            OFS_DET:    rd_val[N-1:0] = det;
            OFS_MON:    rd_val[N-1:0] = lvl;
            default: begin
                for (int i = 0; i < N; i++) begin
                    if (bus_addr == cfg_addr(i)) rd_val[5:0] = r_q.cfg[i];
                end
            end
        endcase

        if (bus_rd) r_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_rdata = r_q.rdata;
    assign irq_out   = det & r_q.en;

    a_r6_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN_SET) |=>
        ((r_q.en & $past(wmask)) == $past(wmask)));

    a_r6_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN_CLR) |=> ((r_q.en & $past(wmask)) == '0));

    a_r6_other_writes_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || (bus_addr != OFS_EN_SET && bus_addr != OFS_EN_CLR)) |=> $stable(r_q.en));

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_EN_CLR) |=> ((irq_out & $past(wmask)) == '0));

endmodule

// File: tb/extint_ctrl_test.sv
`timescale 1ns/1ps
module extint_ctrl_test;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    extint_ctrl #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [5:0] codes [8];
        codes = '{6'h00, 6'h01, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h03, 6'h3F};

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd(12'h004, v); check("R1 enables", v, 0);
        rd(12'h100, v); check("R1 detect", v, 0);
        rd(12'h180, v); check("R1 sense0", v, 0);
        rd(12'h18C, v); check("R1 sense3", v, 0);
        check("R1 irq_out", 32'(irq_out), 0);

        // R6: enable set/clear
        wr(12'h008, 32'h5); rd(12'h004, v); check("R6 set", v, 32'h5);
        wr(12'h008, 32'h2); rd(12'h008, v); check("R6 set accumulates", v, 32'h7);
        wr(12'h004, 32'h4); rd(12'h004, v); check("R6 clear", v, 32'h3);
        wr(12'h004, 32'h0); rd(12'h004, v); check("R6 zero no effect", v, 32'h3);
        wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, v); check("R6 clear all R9 width", v, 0);

        // R9: undecoded address, rdata hold
        rd(12'h040, v); check("R9 undecoded", v, 0);
        idle(2); check("R9 rdata held", bus_rdata, 0);

        // R2 R3 R4 R7 R8: sweep pins x sense codes
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic [5:0] code;
                logic lo, hi, fe, re;
                code = codes[c];
                lo = (code == 6'h01); hi = (code == 6'h02);
                fe = (code == 6'h04) || (code == 6'h0C);
                re = (code == 6'h08) || (code == 6'h0C);

                wr(12'h180 + 12'(4 * p), 32'hFFFF_FFC0 | 32'(code));
                rd(12'h180 + 12'(4 * p), v);
                check("R2 sense readback", v, 32'(code));
                wr(12'h008, 32'(1) << p);
                idle(3);
                wr(12'h100, 32'hF);
                idle(3);
                rd(12'h100, v);
                check("R2 R3 idle low", v, 32'(lo) << p);

                pin_in[p] = 1'b1;
                idle(2);
                rd(12'h104, v);
                check("R8 monitor", v, 32'(1) << p);
                idle(2);
                rd(12'h100, v);
                check("R2 R4 after rise", v, 32'(hi | re) << p);
                check("R7 irq_out", 32'(irq_out), 32'(hi | re) << p);
                rd(12'h000, v);
                check("R7 request", v, 32'(hi | re) << p);

                wr(12'h100, 32'(1) << p);
                idle(1);
                rd(12'h100, v);
                check("R3 R4 after ack", v, 32'(hi) << p);

                pin_in[p] = 1'b0;
                idle(4);
                rd(12'h100, v);
                check("R2 R4 after fall", v, 32'(lo | fe) << p);

                wr(12'h100, 32'h0);
                rd(12'h100, v);
                check("R4 zero write keeps", v, 32'(lo | fe) << p);

                wr(12'h180 + 12'(4 * p), 32'h0);
                wr(12'h004, 32'hF);
                wr(12'h100, 32'hF);
                idle(2);
            end
        end

        // R5: edge and clear in the same cycle
        wr(12'h180, 32'h08);
        pin_in[0] = 1'b1; idle(4);
        pin_in[0] = 1'b0; idle(4);
        rd(12'h100, v); check("R5 setup latched", v, 32'h1);
        pin_in[0] = 1'b1;
        idle(2);
        wr(12'h100, 32'h1);
        rd(12'h100, v); check("R5 edge beats clear", v, 32'h1);
        wr(12'h100, 32'h1);
        rd(12'h100, v); check("R5 later clear works", v, 32'h0);

        // R7: request masks detect with enable
        wr(12'h188, 32'h02);
        pin_in[2] = 1'b1; idle(4);
        rd(12'h000, v); check("R7 masked request", v, 0);
        check("R7 masked irq", 32'(irq_out), 0);
        wr(12'h008, 32'h4);
        rd(12'h000, v); check("R7 unmasked request", v, 32'h4);
        check("R7 unmasked irq", 32'(irq_out), 32'h4);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule